// File: doc/BRIEF.md
# Single-to-Dual Pixel Output Formatter

This block sits at the end of a display pipeline. Each clock it takes one RGB pixel with 8 bits per colour, together with horizontal sync, vertical sync and data-enable. It prepares that pixel for a flat panel. Each colour lane can be shifted right and have its bits reversed. The red and blue lanes can then be exchanged. The stream leaves either one pixel per clock (single-wide) or as pairs of consecutive pixels on an A port and a B port (double-wide, 48 data bits). In double-wide mode a one-cycle `out_ce` pulse marks each new pair and serves as the qualifier for the half-rate panel clock. Inversion of the data is set separately for the A half and the B half, and it is applied after the output register.

The pairing phase is a divide-by-2 toggle. A selected sync edge forces it back to the A slot. The rising edge of data-enable gives per-line alignment, so the first active pixel of every line lands on A whatever the parity of the blanking or active lengths. The rising edge of hsync also gives per-line alignment. The rising edge of vsync aligns the phase once per frame. Video timing cannot stall, so the stream has no ready signal and exerts no back-pressure. A pixel is taken on every clock, and the sync and enable outputs keep the same relation to the data that they had at the input. Configuration inputs are meant to be changed only while reset is asserted.

Top module: `pixel_pair_fmt`

## Requirements
- R1: In single-wide mode (`cfg_dual`=0), a pixel and its hs/vs/de presented in clock n appear on `out_a` and `out_hs`/`out_vs`/`out_de` in clock n+2. `out_a` packs red in [23:16], green in [15:8] and blue in [7:0]. `out_ce` is high every cycle.
- R2: In single-wide mode `out_b` is all zeros, whatever `cfg_inv_b` is set to.
- R3: Each colour lane is first shifted right by `cfg_shift` (0 to 7), and the vacated high bits are filled with zeros.
- R4: With `cfg_flip`=1, each shifted lane has its bit order reversed (bit 0 goes to bit 7). The reversal is applied after the shift.
- R5: With `cfg_swap`=1, the red output field carries the formatted blue input and the blue field carries the formatted red input. Green is left unchanged.
- R6: `cfg_inv_a` inverts every bit of `out_a` and `cfg_inv_b` inverts every bit of `out_b`. Each acts independently of the other, on the data only.
- R7: In double-wide mode, two consecutive pixels form a pair. The earlier pixel (A phase) goes on `out_a` and the later one (B phase) on `out_b`. The pair appears two clocks after the B pixel was presented. In that same cycle `out_ce` pulses for one clock, and `out_hs`/`out_vs`/`out_de` show the syncs of the A pixel. Between pulses all outputs hold, and `out_ce` never stays high two cycles in a row.
- R8: With `cfg_src`=2'b00, a pixel whose data-enable is high while the previous pixel's was low is forced into the A phase. The first active pixel of every line is therefore on `out_a`, even with odd blanking or active lengths.
- R9: With `cfg_src`=2'b01, the pixel on which hsync rises is forced into the A phase.
- R10: With `cfg_src`=2'b10 or 2'b11, only the pixel on which vsync rises resets the phase. After that the phase alternates freely across line boundaries. Any A pixel left unpaired by a resync is dropped.
- R11: While `rst_n` is low the registered outputs are zero, `out_ce` is low, and the first pixel after reset takes the B phase unless it carries the resync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dual | input | 1 | 1 = double-wide pairs, 0 = single-wide |
| cfg_shift | input | 3 | Right-shift amount per colour lane |
| cfg_flip | input | 1 | Reverse bit order within each lane |
| cfg_swap | input | 1 | Exchange red and blue lanes |
| cfg_inv_a | input | 1 | Invert A output data |
| cfg_inv_b | input | 1 | Invert B output data |
| cfg_src | input | 2 | Phase resync source: 00 data-enable, 01 hsync, 1x vsync |
| in_r | input | 8 | Red input |
| in_g | input | 8 | Green input |
| in_b | input | 8 | Blue input |
| in_hs | input | 1 | Horizontal sync input |
| in_vs | input | 1 | Vertical sync input |
| in_de | input | 1 | Data-enable input |
| out_a | output | 24 | A pixel {R,G,B} |
| out_b | output | 24 | B pixel {R,G,B}, zero in single-wide mode |
| out_hs | output | 1 | Horizontal sync output |
| out_vs | output | 1 | Vertical sync output |
| out_de | output | 1 | Data-enable output |
| out_ce | output | 1 | Pair strobe / output clock qualifier |

## Verification
In single-wide mode every result is due exactly two clocks after its pixel was presented. In double-wide mode a pair is due two clocks after its B pixel, and `out_ce` should stay low in every other cycle. The driver works out each expected item from the formatting and phase rules, using its own model of the resync edges. It stamps each item with the clock count at which the item must appear. The monitor samples on the falling edge and compares an item only in its stamped cycle. In double-wide mode it also requires `out_ce` low in each cycle that has no item due, so a pair that comes early, comes late or is missing shows up as a mismatch.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

  typedef enum logic [1:0] {
    SRC_DE  = 2'b00,
    SRC_HS  = 2'b01,
    SRC_VS  = 2'b10
  } sync_src_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;

endpackage

// File: rtl/pxfmt_chan.sv
module pxfmt_chan #(
  parameter int CW  = 8,
  parameter int SHW = 3
) (
  input  logic [CW-1:0]  din,
  input  logic [SHW-1:0] shamt,
  input  logic           flip,
  output logic [CW-1:0]  dout
);
  logic [CW-1:0] shifted;
  logic [CW-1:0] reversed;

  assign shifted = din >> shamt;

  for (genvar i = 0; i < CW; i++) begin : g_rev
    assign reversed[i] = shifted[CW-1-i];
  end

  assign dout = flip ? reversed : shifted;
endmodule

// File: rtl/pxfmt_phase.sv
module pxfmt_phase
  import pxfmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sync_src_e src,
  input  logic      hs,
  input  logic      vs,
  input  logic      de,
  output logic      ph_now
);
  logic hs_q, vs_q, de_q, ph_q;
  logic resync;

  always_comb begin
    case (src)
      SRC_DE:  resync = de & ~de_q;
      SRC_HS:  resync = hs & ~hs_q;
      default: resync = vs & ~vs_q;
    endcase
  end

  assign ph_now = resync ? 1'b0 : ~ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      hs_q <= hs;
      vs_q <= vs;
      de_q <= de;
      ph_q <= ph_now;
    end
  end
endmodule

// File: rtl/pxfmt_pack.sv
module pxfmt_pack
  import pxfmt_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic          inv_a,
  input  logic          inv_b,
  input  logic [PW-1:0] pix,
  input  sync_t         syn,
  input  logic          ph,
  output logic [PW-1:0] pa,
  output logic [PW-1:0] pb,
  output sync_t         osyn,
  output logic          ce
);
  logic [PW-1:0] hold_pix;
  sync_t         hold_syn;
  logic [PW-1:0] reg_a, reg_b;
  sync_t         reg_syn;
  logic          reg_ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_pix <= '0;
      hold_syn <= '0;
      reg_a    <= '0;
      reg_b    <= '0;
      reg_syn  <= '0;
      reg_ce   <= 1'b0;
    end else if (dual) begin
      reg_ce <= ph;
      if (!ph) begin
        hold_pix <= pix;
        hold_syn <= syn;
      end else begin
        reg_a   <= hold_pix;
        reg_b   <= pix;
        reg_syn <= hold_syn;
      end
    end else begin
      reg_ce  <= 1'b1;
      reg_a   <= pix;
      reg_b   <= '0;
      reg_syn <= syn;
    end
  end

  assign pa   = reg_a ^ {PW{inv_a}};
  assign pb   = dual ? (reg_b ^ {PW{inv_b}}) : '0;
  assign osyn = reg_syn;
  assign ce   = reg_ce;
endmodule

// File: rtl/pixel_pair_fmt.sv
module pixel_pair_fmt
  import pxfmt_pkg::*;
#(
  parameter  int CW  = 8,
  localparam int SHW = $clog2(CW),
  localparam int PW  = 3 * CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_dual,
  input  logic [SHW-1:0] cfg_shift,
  input  logic           cfg_flip,
  input  logic           cfg_swap,
  input  logic           cfg_inv_a,
  input  logic           cfg_inv_b,
  input  logic [1:0]     cfg_src,
  input  logic [CW-1:0]  in_r,
  input  logic [CW-1:0]  in_g,
  input  logic [CW-1:0]  in_b,
  input  logic           in_hs,
  input  logic           in_vs,
  input  logic           in_de,
  output logic [PW-1:0]  out_a,
  output logic [PW-1:0]  out_b,
  output logic           out_hs,
  output logic           out_vs,
  output logic           out_de,
  output logic           out_ce
);
  localparam int NCOL = 3;

  logic [CW-1:0] col_in  [NCOL];
  logic [CW-1:0] col_fmt [NCOL];
  logic [PW-1:0] fmt_pix;
  logic          ph_now;

  logic [PW-1:0] s1_pix;
  sync_t         s1_syn;
  logic          s1_ph;
  sync_t         o_syn;

  assign col_in[0] = in_r;
  assign col_in[1] = in_g;
  assign col_in[2] = in_b;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    pxfmt_chan #(.CW(CW), .SHW(SHW)) u_chan (
      .din   (col_in[c]),
      .shamt (cfg_shift),
      .flip  (cfg_flip),
      .dout  (col_fmt[c])
    );
  end

  assign fmt_pix = cfg_swap ? {col_fmt[2], col_fmt[1], col_fmt[0]}
                            : {col_fmt[0], col_fmt[1], col_fmt[2]};

  pxfmt_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (sync_src_e'(cfg_src)),
    .hs     (in_hs),
    .vs     (in_vs),
    .de     (in_de),
    .ph_now (ph_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_pix <= '0;
      s1_syn <= '0;
      s1_ph  <= 1'b0;
    end else begin
      s1_pix <= fmt_pix;
      s1_syn <= '{hs: in_hs, vs: in_vs, de: in_de};
      s1_ph  <= ph_now;
    end
  end

  pxfmt_pack #(.PW(PW)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .dual  (cfg_dual),
    .inv_a (cfg_inv_a),
    .inv_b (cfg_inv_b),
    .pix   (s1_pix),
    .syn   (s1_syn),
    .ph    (s1_ph),
    .pa    (out_a),
    .pb    (out_b),
    .osyn  (o_syn),
    .ce    (out_ce)
  );

  assign out_hs = o_syn.hs;
  assign out_vs = o_syn.vs;
  assign out_de = o_syn.de;
endmodule

// File: rtl/pxfmt_chk.sv
module pxfmt_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_dual,
  input logic [1:0]    cfg_src,
  input logic          in_hs,
  input logic          in_vs,
  input logic          in_de,
  input logic [PW-1:0] out_b,
  input logic          out_hs,
  input logic          out_vs,
  input logic          out_de,
  input logic          out_ce
);
  AST_SINGLE_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> (out_de == $past(in_de, 2) && out_hs == $past(in_hs, 2)
                   && out_vs == $past(in_vs, 2))); // R1

  AST_SINGLE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> out_b == '0); // R2

  AST_CE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dual && out_ce) |=> !out_ce); // R7

  AST_HOLD_BETWEEN_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dual && !out_ce) |-> ($stable(out_de) && $stable(out_hs) && $stable(out_vs))); // R7

  AST_FIRST_ACTIVE_IN_A: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dual && cfg_src == 2'b00 && $past(in_de, 3) && !$past(in_de, 4))
      |-> (out_ce && out_de)); // R8
endmodule

bind pixel_pair_fmt pxfmt_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_dual (cfg_dual),
  .cfg_src  (cfg_src),
  .in_hs    (in_hs),
  .in_vs    (in_vs),
  .in_de    (in_de),
  .out_b    (out_b),
  .out_hs   (out_hs),
  .out_vs   (out_vs),
  .out_de   (out_de),
  .out_ce   (out_ce)
);

// File: tb/sim_pixel_pair_fmt.sv
`timescale 1ns/1ps
module sim_pixel_pair_fmt;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dual = 1'b0, cfg_flip = 1'b0, cfg_swap = 1'b0;
  logic        cfg_inv_a = 1'b0, cfg_inv_b = 1'b0;
  logic [2:0]  cfg_shift = '0;
  logic [1:0]  cfg_src = '0;
  logic [7:0]  in_r = '0, in_g = '0, in_b = '0;
  logic        in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [23:0] out_a, out_b;
  logic        out_hs, out_vs, out_de, out_ce;

  always #(PERIOD/2) clk = ~clk;

  pixel_pair_fmt u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_shift(cfg_shift),
    .cfg_flip(cfg_flip), .cfg_swap(cfg_swap), .cfg_inv_a(cfg_inv_a),
    .cfg_inv_b(cfg_inv_b), .cfg_src(cfg_src), .in_r(in_r), .in_g(in_g),
    .in_b(in_b), .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
    .out_a(out_a), .out_b(out_b), .out_hs(out_hs), .out_vs(out_vs),
    .out_de(out_de), .out_ce(out_ce)
  );

  typedef struct {
    int          due;
    logic [23:0] a;
    logic [23:0] b;
    logic [2:0]  syn;
  } exp_t;

  exp_t  q[$];
  exp_t  mon_e;
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  int    pc = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R11";

  logic        m_hs, m_vs, m_de, m_ph;
  logic [23:0] m_hold;
  logic [2:0]  m_hsyn;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] lane(logic [7:0] x);
    logic [7:0] s, r;
    s = x >> cfg_shift;
    for (int i = 0; i < 8; i++) r[i] = s[7-i];
    return cfg_flip ? r : s;
  endfunction

  function automatic logic [23:0] fmt(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return cfg_swap ? {lane(b), lane(g), lane(r)} : {lane(r), lane(g), lane(b)};
  endfunction

  // driver: presents one pixel, pushes the expected result with its due cycle
  task automatic drv(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic hs, logic vs, logic de);
    logic [23:0] f;
    logic        ev, ph;
    exp_t        e;
    in_r = r; in_g = g; in_b = b; in_hs = hs; in_vs = vs; in_de = de;
    f = fmt(r, g, b);
    e.due = cyc + 2;
    if (cfg_dual) begin
      if (cfg_src == 2'b00)      ev = de & ~m_de;
      else if (cfg_src == 2'b01) ev = hs & ~m_hs;
      else                       ev = vs & ~m_vs;
      ph = ev ? 1'b0 : ~m_ph;
      if (!ph) begin
        m_hold = f;
        m_hsyn = {hs, vs, de};
      end else begin
        e.a   = m_hold ^ {24{cfg_inv_a}};
        e.b   = f ^ {24{cfg_inv_b}};
        e.syn = m_hsyn;
        q.push_back(e);
      end
      m_ph = ph;
    end else begin
      e.a   = f ^ {24{cfg_inv_a}};
      e.b   = '0;
      e.syn = {hs, vs, de};
      q.push_back(e);
    end
    m_hs = hs; m_vs = vs; m_de = de;
    @(negedge clk);
  endtask

  // monitor: compares items in their due cycle, expects no strobe otherwise in dual mode
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        mon_e = q.pop_front();
        chk(cur_req, "data{a,b}", {out_a, out_b}, {mon_e.a, mon_e.b});
        chk(cur_req, "ctrl{ce,hs,vs,de}", {44'd0, out_ce, out_hs, out_vs, out_de},
            {44'd0, 1'b1, mon_e.syn});
      end else if (cfg_dual) begin
        chk(cur_req, "idle strobe", {47'd0, out_ce}, 48'd0);
      end
    end
  end

  task automatic start(string req, bit dual, int sh, bit fl, bit sw, bit ia, bit ib, int src);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    in_r = '0; in_g = '0; in_b = '0; in_hs = 1'b0; in_vs = 1'b0; in_de = 1'b0;
    cfg_dual = dual; cfg_shift = 3'(sh); cfg_flip = fl; cfg_swap = sw;
    cfg_inv_a = ia; cfg_inv_b = ib; cfg_src = 2'(src);
    repeat (3) @(negedge clk);
    q.delete();
    m_hs = 1'b0; m_vs = 1'b0; m_de = 1'b0; m_ph = 1'b0;
    m_hold = '0; m_hsyn = '0;
    cur_req = req;
    mon_en = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic line(int hsw, int bp, int act, int fp, bit vsl);
    for (int i = 0; i < hsw + bp + act + fp; i++) begin
      pc++;
      drv(8'(pc * 7 + 1), 8'(pc * 13 + 5), 8'(pc) ^ 8'h5a,
          i < hsw, vsl, (i >= hsw + bp) && (i < hsw + bp + act));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv('0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    // R11: outputs held at zero in reset (inversion off)
    start("R11", 1'b1, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    mon_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "reset data", {out_a, out_b}, 48'd0);
    chk("R11", "reset ctrl", {44'd0, out_ce, out_hs, out_vs, out_de}, 48'd0);
    // R11: first pixel after reset with no edge is a B pixel (pairs with zero hold)
    start("R11", 1'b1, 0, 0, 0, 0, 0, 2);
    idle(1); line(0, 0, 3, 0, 1'b0); idle(3);

    start("R1", 1'b0, 0, 0, 0, 0, 0, 0);
    line(3, 2, 8, 3, 1'b1); line(3, 2, 8, 3, 1'b0); idle(3);

    start("R2", 1'b0, 0, 0, 0, 1, 1, 0);
    line(2, 3, 6, 2, 1'b0); idle(3);

    start("R3", 1'b0, 3, 0, 0, 0, 0, 0);
    line(2, 2, 6, 2, 1'b0); idle(3);
    start("R3", 1'b0, 7, 0, 0, 0, 0, 0);
    line(2, 2, 6, 2, 1'b0); idle(3);

    start("R4", 1'b0, 2, 1, 0, 0, 0, 0);
    line(2, 2, 6, 2, 1'b0); idle(3);

    start("R5", 1'b0, 1, 1, 1, 0, 0, 0);
    line(2, 2, 6, 2, 1'b0); idle(3);

    start("R7", 1'b1, 0, 0, 0, 0, 0, 0);
    line(2, 2, 8, 2, 1'b0); line(2, 2, 8, 2, 1'b0); idle(3);

    start("R8", 1'b1, 0, 0, 0, 0, 0, 0);
    line(3, 2, 7, 2, 1'b0); line(3, 3, 5, 2, 1'b0);
    line(2, 3, 7, 3, 1'b0); line(1, 1, 1, 2, 1'b0); idle(3);

    start("R6", 1'b1, 0, 0, 0, 1, 0, 0);
    line(3, 2, 7, 2, 1'b0); idle(3);
    start("R6", 1'b1, 0, 0, 0, 0, 1, 0);
    line(3, 2, 7, 2, 1'b0); idle(3);

    start("R9", 1'b1, 0, 0, 0, 0, 0, 1);
    line(2, 2, 6, 3, 1'b0); line(2, 2, 6, 3, 1'b0); line(2, 2, 5, 2, 1'b0); idle(3);

    start("R10", 1'b1, 0, 0, 0, 0, 0, 2);
    line(2, 2, 6, 3, 1'b1); line(2, 2, 6, 3, 1'b0); line(2, 2, 6, 3, 1'b0);
    line(2, 2, 6, 3, 1'b1); line(2, 2, 6, 3, 1'b0); idle(3);
    start("R10", 1'b1, 0, 0, 0, 0, 0, 3);
    line(2, 1, 6, 3, 1'b1); line(2, 1, 6, 3, 1'b0); idle(3);

    mon_en = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule